// File: doc/BRIEF.md
# Cross-Channel Response Normalizer

This block scales every feature value of one spatial position by a factor that falls as the energy of its neighbourhood rises. The energy is the sum of the squares of the feature values in channels at most a runtime radius away from the channel being scaled. The factor follows the curve g(x) = 2^12 · K / (K + x) with K = 256. It is produced by a piecewise-linear approximation whose pieces lie on power-of-two boundaries. The leading-one position of the sum picks the octave. The bits just below the leading one pick the piece inside that octave. No comparator search over piece limits is needed.

The block is used in two phases. While idle, a host writes the feature values of one position into a local buffer, one channel per cycle. A start pulse closes that phase and acts as a barrier. The block then visits the channels in order. For each channel it spends one cycle gathering the window's sum of squares and one cycle on lookup, interpolation and the final multiply. Results go to a result buffer. Only after every channel is finished does the block stream them out, one per cycle in channel order. The buffer keeps its contents between runs.

The controller has four states:
- IDLE: accepts loads and start.
- GATHER: registers the window sum and the centre value.
- SCALE: stores the scaled result.
- DRAIN: emits the results.

It has five transitions:
- IDLE→GATHER: on an accepted start.
- GATHER→SCALE: always.
- SCALE→GATHER: when more channels remain.
- SCALE→DRAIN: after the last channel.
- DRAIN→IDLE: on the final beat.

Top module: `cross_norm_unit`

## Requirements
- R1: A load (`ld_en`) writes `ld_val` into channel `ld_ch` of the buffer only while `busy` is low. Loads while `busy` is high change nothing. Buffer contents survive between runs.
- R2: A load and an accepted start in the same cycle both take effect. The loaded value takes part in that run.
- R3: The sum for channel c covers the channels c-r through c+r, where r is `radius` clamped to RAD_MAX (2). Each in-range channel contributes the square of its signed value. Channels below 0 or at or above the count contribute zero.
- R4: The factor is a piecewise-linear approximation of g(x) = 4096·256/(256+x), with these pieces:
  - Sums below 2^S (S = 2) use one exact entry each, and a zero sum has its own entry.
  - For a larger sum with leading one at bit e, the S bits below bit e select one of 2^S pieces of width 2^(e-S).
  - Each piece takes its end values from g at its end points and interpolates linearly in between.
- R5: Sums of 2^16 or more are evaluated as 65535, which is the last table piece.
- R6: Each output equals the feature value times the factor, plus 2048, arithmetically shifted right by 12. Its distance from the real value v·g(x)/4096 is at most 0.5 + |v|·(4096/(27·4^S)+3)/4096.
- R7: Suppose start is accepted at clock edge k with effective count n. Then `out_valid` first goes high after edge k+2n. It then stays high for n consecutive cycles with `out_ch` = 0..n-1. `out_last` is high on the final beat only, and `busy` is low after it.
- R8: A start with `ch_count` of 0 is ignored. A count above CH_MAX (16) runs CH_MAX channels.
- R9: A start while `busy` is high is ignored. The running job keeps its count, timing and results.
- R10: After reset, `busy` and `out_valid` are low and every buffer entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Buffer write strobe |
| ld_ch | input | 4 | Channel written by a load |
| ld_val | input | 8 | Signed feature value to load |
| start | input | 1 | Begin a normalization run |
| ch_count | input | 5 | Number of channels in the run |
| radius | input | 3 | Neighbourhood radius |
| busy | output | 1 | High from an accepted start to the final beat |
| out_valid | output | 1 | Result beat valid |
| out_last | output | 1 | Final result beat |
| out_ch | output | 4 | Channel of the current beat |
| out_val | output | 8 | Signed normalized value |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a buffer write and the start of processing. The bench drives `ld_en` and `start` on the same edge, with a value that differs from the one held before. It judges the result against a reference that includes the new value.

The second pair is a running job and a new start or load. During a run, the bench pulses `start` with a different count and writes a channel. It then checks that the beat count, the latency and every result still follow the original job and the original data. A later run without reloading confirms that the write never reached the buffer.

// File: rtl/cnorm_pkg.sv
package cnorm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_SCALE,
        ST_DRAIN
    } cnorm_state_e;

    // Target curve in fixed point: 2^frac_w * k / (k + x)
    function automatic longint curve_at(longint x, int frac_w, int k);
        return ((longint'(1) << frac_w) * longint'(k)) / (longint'(k) + x);
    endfunction

    // Left end of table piece i (pieces below 2^s are single points)
    function automatic longint piece_x0(int i, int s);
        int e;
        int sub;
        if (i < (1 << s)) begin
            return longint'(i);
        end
        e   = i / (1 << s) + s - 1;
        sub = i % (1 << s);
        return (longint'(1) << e) + longint'(sub) * (longint'(1) << (e - s));
    endfunction

    // Width of table piece i
    function automatic longint piece_len(int i, int s);
        int e;
        if (i < (1 << s)) begin
            return 64'sd1;
        end
        e = i / (1 << s) + s - 1;
        return longint'(1) << (e - s);
    endfunction

endpackage

// File: rtl/cnorm_window.sv
module cnorm_window #(
    parameter int DATA_W  = 8,
    parameter int CH_MAX  = 16,
    parameter int RAD_MAX = 2,
    parameter int SUM_W   = 19,
    parameter int CI_W    = 4,
    parameter int CNT_W   = 5,
    parameter int RAD_W   = 3
) (
    input  logic signed [DATA_W-1:0] feat_mem [CH_MAX],
    input  logic        [CI_W-1:0]   center,
    input  logic        [CNT_W-1:0]  count,
    input  logic        [RAD_W-1:0]  radius,
    output logic        [SUM_W-1:0]  sum_sq
);
    localparam int TAPS = 2 * RAD_MAX + 1;

    logic [SUM_W-1:0] tap_sq [TAPS];
    int               eff_rad;

    always_comb begin
        eff_rad = (32'(radius) > RAD_MAX) ? RAD_MAX : int'(32'(radius));
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        localparam int OFS  = t - RAD_MAX;
        localparam int DIST = (OFS < 0) ? -OFS : OFS;
        int                        pos;
        logic signed [DATA_W-1:0]  val;
        logic signed [2*DATA_W-1:0] prod;
        always_comb begin
            pos  = int'(32'(center)) + OFS;
            val  = feat_mem[pos[CI_W-1:0]];
            prod = val * val;
            if (pos >= 0 && pos < int'(32'(count)) && DIST <= eff_rad) begin
                tap_sq[t] = SUM_W'($unsigned(prod));
            end else begin
                tap_sq[t] = '0;
            end
        end
    end

    always_comb begin
        sum_sq = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum_sq = sum_sq + tap_sq[t];
        end
    end

endmodule

// File: rtl/cnorm_pwl.sv
module cnorm_pwl
    import cnorm_pkg::*;
#(
    parameter int SUM_W    = 19,
    parameter int SUB_BITS = 2,
    parameter int TOP_EXP  = 15,
    parameter int FRAC_W   = 12,
    parameter int CURVE_K  = 256
) (
    input  logic [SUM_W-1:0]  sum_in,
    output logic [FRAC_W:0]   factor
);
    localparam int XW    = TOP_EXP + 1;
    localparam int SEGS  = 1 << SUB_BITS;
    localparam int N_ENT = SEGS * (TOP_EXP - SUB_BITS + 2);
    localparam int IDX_W = $clog2(N_ENT);

    logic [FRAC_W:0] icpt_tbl [N_ENT];
    logic [FRAC_W:0] drop_tbl [N_ENT];

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_tbl
        localparam longint X0  = piece_x0(gi, SUB_BITS);
        localparam longint LEN = piece_len(gi, SUB_BITS);
        localparam longint Y0  = curve_at(X0, FRAC_W, CURVE_K);
        localparam longint Y1  = curve_at(X0 + LEN, FRAC_W, CURVE_K);
        assign icpt_tbl[gi] = (FRAC_W + 1)'(Y0);
        assign drop_tbl[gi] = (FRAC_W + 1)'(Y0 - Y1);
    end

    logic [31:0] x_sat;
    logic [31:0] lead;
    logic [31:0] shf;
    logic [31:0] sub;
    logic [31:0] idx;
    logic [31:0] off;
    logic [31:0] dec;

    always_comb begin
        if (|sum_in[SUM_W-1:XW]) begin
            x_sat = (32'd1 << XW) - 32'd1;
        end else begin
            x_sat = 32'(sum_in[XW-1:0]);
        end
        lead = '0;
        for (int b = 0; b < XW; b++) begin
            if (x_sat[b]) begin
                lead = 32'(b);
            end
        end
        if (x_sat < 32'(SEGS)) begin
            shf = '0;
            sub = '0;
            idx = x_sat;
            off = '0;
        end else begin
            shf = lead - 32'(SUB_BITS);
            sub = (x_sat >> shf) & 32'(SEGS - 1);
            idx = (shf + 32'd1) * 32'(SEGS) + sub;
            off = x_sat & ((32'd1 << shf) - 32'd1);
        end
        dec    = (32'(drop_tbl[idx[IDX_W-1:0]]) * off) >> shf;
        factor = icpt_tbl[idx[IDX_W-1:0]] - (FRAC_W + 1)'(dec);
    end

endmodule

// File: rtl/cross_norm_unit.sv
module cross_norm_unit
    import cnorm_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CH_MAX   = 16,
    parameter int RAD_MAX  = 2,
    parameter int SUB_BITS = 2,
    parameter int TOP_EXP  = 15,
    parameter int FRAC_W   = 12,
    parameter int CURVE_K  = 256,
    localparam int CI_W    = $clog2(CH_MAX),
    localparam int CNT_W   = $clog2(CH_MAX + 1),
    localparam int RAD_W   = $clog2(RAD_MAX + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [CI_W-1:0]          ld_ch,
    input  logic signed [DATA_W-1:0] ld_val,
    input  logic                     start,
    input  logic [CNT_W-1:0]         ch_count,
    input  logic [RAD_W-1:0]         radius,
    output logic                     busy,
    output logic                     out_valid,
    output logic                     out_last,
    output logic [CI_W-1:0]          out_ch,
    output logic signed [DATA_W-1:0] out_val
);
    localparam int SUM_W = 2 * DATA_W + $clog2(2 * RAD_MAX + 1) + 1;

    cnorm_state_e state_q, state_d;

    logic signed [DATA_W-1:0] feat_mem [CH_MAX];
    logic signed [DATA_W-1:0] res_mem  [CH_MAX];
    logic [CI_W-1:0]          ch_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [RAD_W-1:0]         rad_q;
    logic [SUM_W-1:0]         sum_q;
    logic signed [DATA_W-1:0] ctr_q;

    logic [SUM_W-1:0]         win_sum;
    logic [FRAC_W:0]          factor;
    logic signed [31:0]       prod;
    logic signed [31:0]       rounded;
    logic                     take_start;
    logic                     last_ch;
    logic [CNT_W-1:0]         cnt_eff;

    cnorm_window #(
        .DATA_W (DATA_W),
        .CH_MAX (CH_MAX),
        .RAD_MAX(RAD_MAX),
        .SUM_W  (SUM_W),
        .CI_W   (CI_W),
        .CNT_W  (CNT_W),
        .RAD_W  (RAD_W)
    ) u_window (
        .feat_mem(feat_mem),
        .center  (ch_q),
        .count   (cnt_q),
        .radius  (rad_q),
        .sum_sq  (win_sum)
    );

    cnorm_pwl #(
        .SUM_W   (SUM_W),
        .SUB_BITS(SUB_BITS),
        .TOP_EXP (TOP_EXP),
        .FRAC_W  (FRAC_W),
        .CURVE_K (CURVE_K)
    ) u_pwl (
        .sum_in(sum_q),
        .factor(factor)
    );

    always_comb begin
        take_start = start && (state_q == ST_IDLE) && (ch_count != '0);
        cnt_eff    = (32'(ch_count) > CH_MAX) ? CNT_W'(CH_MAX) : ch_count;
        last_ch    = (32'(ch_q) + 32'd1 == 32'(cnt_q));
        prod       = 32'(ctr_q) * $signed({1'b0, 31'(factor)});
        rounded    = (prod + (32'sd1 <<< (FRAC_W - 1))) >>> FRAC_W;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_start) state_d = ST_GATHER;
            ST_GATHER: state_d = ST_SCALE;
            ST_SCALE:  state_d = last_ch ? ST_DRAIN : ST_GATHER;
            ST_DRAIN:  if (last_ch) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            cnt_q <= '0;
            rad_q <= '0;
            sum_q <= '0;
            ctr_q <= '0;
            for (int i = 0; i < CH_MAX; i++) begin
                feat_mem[i] <= '0;
                res_mem[i]  <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ld_en) begin
                        feat_mem[ld_ch] <= ld_val;
                    end
                    if (take_start) begin
                        cnt_q <= cnt_eff;
                        rad_q <= radius;
                        ch_q  <= '0;
                    end
                end
                ST_GATHER: begin
                    sum_q <= win_sum;
                    ctr_q <= feat_mem[ch_q];
                end
                ST_SCALE: begin
                    res_mem[ch_q] <= rounded[DATA_W-1:0];
                    ch_q <= last_ch ? '0 : ch_q + 1'b1;
                end
                ST_DRAIN: begin
                    ch_q <= last_ch ? '0 : ch_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_ch    = '0;
        out_val   = '0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_GATHER: ;
            ST_SCALE:  ;
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_last  = last_ch;
                out_ch    = ch_q;
                out_val   = res_mem[ch_q];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cnorm_checker.sv
module cnorm_checker #(
    parameter int CH_MAX = 16,
    localparam int CI_W  = $clog2(CH_MAX),
    localparam int CNT_W = $clog2(CH_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] ch_count,
    input logic             busy,
    input logic             out_valid,
    input logic             out_last,
    input logic [CI_W-1:0]  out_ch
);

    assert_valid_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_beats_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && out_ch == $past(out_ch) + 1'b1));

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !busy);

    assert_first_beat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_ch == '0));

    assert_run_not_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_last) |=> busy);

    assert_zero_count_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && ch_count == '0) |=> !busy);

    assert_last_is_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

bind cross_norm_unit cnorm_checker #(.CH_MAX(CH_MAX)) i_cnorm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ch_count (ch_count),
    .busy     (busy),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_ch   (out_ch)
);

// File: tb/test_cross_norm_unit.sv
module test_cross_norm_unit;
    localparam int NCH = 16;
    localparam int SB  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_en = 1'b0;
    logic [3:0]       ld_ch = '0;
    logic signed [7:0] ld_val = '0;
    logic             start = 1'b0;
    logic [4:0]       ch_count = '0;
    logic [2:0]       radius = '0;
    logic             busy, out_valid, out_last;
    logic [3:0]       out_ch;
    logic signed [7:0] out_val;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ref_mem [NCH];

    always #2 clk = ~clk;

    cross_norm_unit i_cross_norm_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_ch(ld_ch), .ld_val(ld_val),
        .start(start), .ch_count(ch_count), .radius(radius), .busy(busy),
        .out_valid(out_valid), .out_last(out_last), .out_ch(out_ch), .out_val(out_val)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input real act, input real exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0f expected %0f", req, act, exp);
        end
    endtask

    function automatic real ref_norm(int ch, int cnt, int rad);
        int r = (rad > 2) ? 2 : rad;
        longint s = 0;
        real g;
        for (int d = -r; d <= r; d++) begin
            if (ch + d >= 0 && ch + d < cnt) s += ref_mem[ch + d] * ref_mem[ch + d];
        end
        if (s > 65535) s = 65535;
        g = 4096.0 * 256.0 / (256.0 + real'(s));
        return real'(ref_mem[ch]) * g / 4096.0;
    endfunction

    function automatic real err_bound(int v);
        real ef = 4096.0 / (27.0 * real'(1 << (2 * SB))) + 3.0;
        int av = (v < 0) ? -v : v;
        return 0.5 + real'(av) * ef / 4096.0;
    endfunction

    task automatic load(input int ch, input int v);
        @(negedge clk);
        ld_en = 1'b1; ld_ch = 4'(ch); ld_val = 8'(v);
        @(negedge clk);
        ld_en = 1'b0;
        if (!busy) ref_mem[ch] = v;
    endtask

    // start at the next edge; optional noise during the run; optional load on start cycle
    task automatic run(input int cnt_in, input int rad, input bit noise, input bit co_load,
                       input int co_ch, input int co_val, input string tag);
        int n = (cnt_in > NCH) ? NCH : cnt_in;
        int lat = 0;
        @(negedge clk);
        start = 1'b1; ch_count = 5'(cnt_in); radius = 3'(rad);
        if (co_load) begin
            ld_en = 1'b1; ld_ch = 4'(co_ch); ld_val = 8'(co_val);
            ref_mem[co_ch] = co_val;
        end
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        while (!out_valid && lat < 200) begin
            if (noise && lat == 1) begin
                start = 1'b1; ch_count = 5'd1; ld_en = 1'b1; ld_ch = 4'd0; ld_val = 8'sd99;
            end else begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0; ld_en = 1'b0;
        check(lat == 2 * n, {"R7 latency ", tag}, real'(lat), real'(2 * n));
        for (int b = 0; b < n; b++) begin
            real e = ref_norm(b, n, rad);
            real d = real'(out_val) - e;
            if (d < 0.0) d = -d;
            check(out_valid && out_ch == 4'(b), {"R7 beat order ", tag}, real'(out_ch), real'(b));
            check(out_last == (b == n - 1), {"R7 last flag ", tag}, real'(out_last), real'(b == n - 1));
            check(d <= err_bound(ref_mem[b]), {"R6 value ", tag}, real'(out_val), e);
            @(negedge clk);
        end
        check(!busy && !out_valid, {"R9 idle after run ", tag}, real'(busy), 0.0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) ref_mem[i] = 0;
        repeat (3) @(negedge clk);
        check(!busy && !out_valid, "R10 reset outputs", real'(busy), 0.0);
        rst_n = 1'b1;
        // R10: untouched buffer reads as zero
        run(16, 2, 0, 0, 0, 0, "R10 zero buffer");
        // R8: zero count ignored
        @(negedge clk);
        start = 1'b1; ch_count = 5'd0;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R8 zero count", real'(busy), 0.0);
        // R4: small sums, exact pieces
        load(0, 1); load(1, 0);
        run(2, 0, 0, 0, 0, 0, "R4 small sum");
        // R3: edges and radius clamp; R5: saturation
        for (int i = 0; i < NCH; i++) load(i, (i % 2 == 0) ? 127 : -128);
        run(31, 3, 0, 0, 0, 0, "R5 saturate R8 clamp");
        for (int i = 0; i < NCH; i++) load(i, 0);
        load(0, 60); load(15, -70); load(2, 40);
        run(16, 2, 0, 0, 0, 0, "R3 edges");
        run(3, 1, 0, 0, 0, 0, "R3 short count");
        // R2: load on the start cycle
        run(4, 2, 0, 1, 1, 100, "R2 same cycle");
        // R1 and R9: noise during run, then retained buffer
        for (int k = 0; k < 24; k++) begin
            int cnt = 1 + int'($urandom % 16);
            int rad = int'($urandom % 4);
            for (int i = 0; i < NCH; i++) load(i, int'($urandom % 256) - 128);
            run(cnt, rad, k % 3 == 0, 0, 0, 0, "R1 R9 random");
            if (k % 3 == 0) run(cnt, rad, 0, 0, 0, 0, "R1 retained buffer");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule